// File: doc/BRIEF.md
# Program-Counter Data Capture Trap

This block watches the program counter of a signal-processing core. When the counter matches a programmed trap address on a valid cycle, the block copies one of several internal datapath words into a capture register. Two capture units are built. They share one decoder and each sits at its own control address. Unit 0 drives a parallel capture output. Unit 1 drives the word that feeds a serial-out path.

The host reaches the block through a byte-framed control port. The port carries a frame-active level, a byte strobe and a byte bus. Every frame opens with two address bytes:

- The first byte holds five zero bits, then a direction bit, then address bits 9 and 8.
- The second byte holds address bits 7 to 0.

A setup write adds two payload bytes. Together they pack the 9-bit trap counter and a 2-bit source select. A read returns one zero byte and then the captured 24-bit word, one byte per slot.

Top module: `pc_trap_capture`

## Requirements
- R1: After reset, `cap_data`, `ser_data` and `rd_byte` are zero. Each unit starts with trap counter 0 and select 0, so a valid counter value of 0 captures source 0.
- R2: First byte of a frame: bits [7:3] must all be zero, or the rest of the frame is ignored. Bit 2 is 1 for a read and 0 for a write. Bits [1:0] are address [9:8]. The second byte is address [7:0].
- R3: Setup write payload. Byte 2 bits [2:0] are trap counter [8:6], and its bits [7:3] are ignored. Byte 3 bits [7:2] are counter [5:0], and bits [1:0] are the select. The new setting applies from the cycle after byte 3 is accepted.
- R4: On a clock edge where `pc_vld` is 1 and `pc_val` equals the unit's trap counter, the unit loads source `sel`, which is `reg_src[24*sel+23:24*sel]`. The new value is visible after that edge. With no match, the capture holds.
- R5: Unit 0 is at address 0x0F0 and drives `cap_data`. Unit 1 is at address 0x0F1 and drives `ser_data`. Each unit's setting and capture are independent of the other's.
- R6: Read slots. While k bytes of a read frame have been accepted, `rd_byte` shows slot k:
  - slot 2 shows 0x00;
  - slots 3, 4 and 5 show data [23:16], [15:8] and [7:0].

  Every other slot, every write frame, and any unknown address give 0.
- R7: A read returns the capture value as it stood when its second address byte was accepted. A capture on that same edge is not returned.
- R8: These are ignored: writes to addresses other than the two units, bytes beyond the fourth, and frames that end early. Dropping frame-active resets the byte count.
- R9: A setup write that commits on the same edge as a counter match is not used for that match. The match uses the old trap counter and select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_act | input | 1 | High while a control frame is in progress |
| byte_vld | input | 1 | Accepts `byte_in` on this edge |
| byte_in | input | 8 | Control byte from host |
| rd_byte | output | 8 | Read data for the current byte slot |
| pc_vld | input | 1 | Program counter valid strobe |
| pc_val | input | 9 | Core program counter |
| reg_src | input | 96 | Four 24-bit candidate words, source k at bits 24k+23:24k |
| cap_data | output | 24 | Capture register of unit 0 |
| ser_data | output | 24 | Capture register of unit 1 (serial-out feed) |

## Verification
Each result has a fixed point at which it is due:

- A counter match shows on the capture outputs one edge after the strobe is sampled.
- A setup write applies one edge after its fourth byte.
- Read bytes are combinational from the accepted-byte count. They are valid in the idle half-cycle before the next byte strobe.

The bench drives inputs on falling edges, clears each strobe one cycle later, and samples at the next falling edge. Every comparison therefore lands exactly one edge after its cause. The full 512-entry counter sweep checks both the match and a near-miss. Same-edge collisions are set up by raising the counter strobe within the very cycle that carries the committing byte.

// File: rtl/pct_pkg.sv
package pct_pkg;
   localparam int HDR_ZERO_W = 5;
   localparam int DATA_BYTES = 3;

   typedef enum logic [2:0] {
      SLOT_HDR  = 3'd0,
      SLOT_ADR  = 3'd1,
      SLOT_PAY0 = 3'd2,
      SLOT_PAY1 = 3'd3,
      SLOT_D1   = 3'd4,
      SLOT_D0   = 3'd5,
      SLOT_XTRA = 3'd6,
      SLOT_SAT  = 3'd7
   } slot_t;
endpackage

// File: rtl/pct_frame.sv
module pct_frame
   import pct_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int PC_W   = 9,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_act,
   input  logic              byte_vld,
   input  logic [7:0]        byte_in,
   output logic [2:0]        slot,
   output logic              rd_frame,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [PC_W-1:0]   wr_pc,
   output logic [SEL_W-1:0]  wr_sel
);
   localparam int LO_W = 8 - SEL_W;
   localparam int HI_W = PC_W - LO_W;
   localparam int AHI_W = ADDR_W - 8;

   logic [2:0]       cnt_q;
   logic             hdr_ok_q;
   logic             rw_q;
   logic [AHI_W-1:0] ahi_q;
   logic [7:0]       alo_q;
   logic [HI_W-1:0]  phi_q;
   logic             take;

   assign take = frm_act && byte_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= SLOT_HDR;
         hdr_ok_q <= 1'b0;
         rw_q     <= 1'b0;
         ahi_q    <= '0;
         alo_q    <= '0;
         phi_q    <= '0;
      end else if (!frm_act) begin
         cnt_q    <= SLOT_HDR;
         hdr_ok_q <= 1'b0;
      end else if (byte_vld) begin
         if (cnt_q != SLOT_SAT) cnt_q <= cnt_q + 3'd1;
         case (cnt_q)
            SLOT_HDR: begin
               hdr_ok_q <= (byte_in[7:8-HDR_ZERO_W] == '0);
               rw_q     <= byte_in[2];
               ahi_q    <= byte_in[AHI_W-1:0];
            end
            SLOT_ADR:  alo_q <= byte_in;
            SLOT_PAY0: phi_q <= byte_in[HI_W-1:0];
            default: ;
         endcase
      end
   end

   assign slot     = cnt_q;
   assign rd_frame = hdr_ok_q && rw_q;
   assign rd_req   = take && (cnt_q == SLOT_ADR) && hdr_ok_q && rw_q;
   assign rd_addr  = {ahi_q, byte_in};
   assign wr_req   = take && (cnt_q == SLOT_PAY1) && hdr_ok_q && !rw_q;
   assign wr_addr  = {ahi_q, alo_q};
   assign wr_pc    = {phi_q, byte_in[7:SEL_W]};
   assign wr_sel   = byte_in[SEL_W-1:0];
endmodule

// File: rtl/pct_trap.sv
module pct_trap #(
   parameter int              ADDR_W  = 10,
   parameter int              PC_W    = 9,
   parameter int              SEL_W   = 2,
   parameter int              N_SRC   = 4,
   parameter int              DATA_W  = 24,
   parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_req,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [PC_W-1:0]         wr_pc,
   input  logic [SEL_W-1:0]        wr_sel,
   input  logic                    pc_vld,
   input  logic [PC_W-1:0]         pc_val,
   input  logic [N_SRC*DATA_W-1:0] src,
   output logic [DATA_W-1:0]       cap
);
   logic [PC_W-1:0]   trap_q;
   logic [SEL_W-1:0]  sel_q;
   logic [DATA_W-1:0] cap_q;
   logic [DATA_W-1:0] pick;

   always_comb begin
      pick = '0;
      for (int k = 0; k < N_SRC; k++)
         if (sel_q == SEL_W'(k)) pick = src[k*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_q <= '0;
         sel_q  <= '0;
      end else if (wr_req && (wr_addr == MY_ADDR)) begin
         trap_q <= wr_pc;
         sel_q  <= wr_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cap_q <= '0;
      else if (pc_vld && pc_val == trap_q) cap_q <= pick;
   end

   assign cap = cap_q;
endmodule

// File: rtl/pc_trap_capture.sv
module pc_trap_capture
   import pct_pkg::*;
#(
   parameter int              ADDR_W   = 10,
   parameter int              PC_W     = 9,
   parameter int              N_SRC    = 4,
   parameter int              DATA_W   = 24,
   parameter logic [ADDR_W-1:0] CAP_BASE = 10'h0F0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frm_act,
   input  logic                    byte_vld,
   input  logic [7:0]              byte_in,
   output logic [7:0]              rd_byte,
   input  logic                    pc_vld,
   input  logic [PC_W-1:0]         pc_val,
   input  logic [N_SRC*DATA_W-1:0] reg_src,
   output logic [DATA_W-1:0]       cap_data,
   output logic [DATA_W-1:0]       ser_data
);
   localparam int SEL_W = $clog2(N_SRC);
   localparam int N_CAP = 2;

   if (DATA_W != 8 * DATA_BYTES) begin : g_bad_data
      $error("DATA_W must fill the three read data bytes");
   end
   if (PC_W + SEL_W != 11 || PC_W <= 8 - SEL_W) begin : g_bad_pack
      $error("PC_W and select must pack into the two payload bytes");
   end
   if (ADDR_W != 10) begin : g_bad_addr
      $error("ADDR_W must be 10");
   end

   logic [2:0]        byte_cnt;
   logic              rd_frame;
   logic              rd_req;
   logic [ADDR_W-1:0] rd_addr;
   logic              wr_req;
   logic [ADDR_W-1:0] wr_addr;
   logic [PC_W-1:0]   wr_pc;
   logic [SEL_W-1:0]  wr_sel;
   logic [DATA_W-1:0] caps [N_CAP];
   logic [DATA_W-1:0] snap_q;
   logic [DATA_W-1:0] snap_d;

   pct_frame #(.ADDR_W(ADDR_W), .PC_W(PC_W), .SEL_W(SEL_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .frm_act(frm_act), .byte_vld(byte_vld),
      .byte_in(byte_in), .slot(byte_cnt), .rd_frame(rd_frame),
      .rd_req(rd_req), .rd_addr(rd_addr), .wr_req(wr_req),
      .wr_addr(wr_addr), .wr_pc(wr_pc), .wr_sel(wr_sel)
   );

   for (genvar i = 0; i < N_CAP; i++) begin : g_unit
      pct_trap #(
         .ADDR_W(ADDR_W), .PC_W(PC_W), .SEL_W(SEL_W), .N_SRC(N_SRC),
         .DATA_W(DATA_W), .MY_ADDR(CAP_BASE + ADDR_W'(i))
      ) u_trap (
         .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
         .wr_pc(wr_pc), .wr_sel(wr_sel), .pc_vld(pc_vld), .pc_val(pc_val),
         .src(reg_src), .cap(caps[i])
      );
   end

   always_comb begin
      snap_d = '0;
      for (int i = 0; i < N_CAP; i++)
         if (rd_addr == CAP_BASE + ADDR_W'(i)) snap_d = caps[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      snap_q <= '0;
      else if (rd_req) snap_q <= snap_d;
   end

   always_comb begin
      rd_byte = 8'h00;
      if (rd_frame) begin
         case (byte_cnt)
            SLOT_PAY1: rd_byte = snap_q[23:16];
            SLOT_D1:   rd_byte = snap_q[15:8];
            SLOT_D0:   rd_byte = snap_q[7:0];
            default:   rd_byte = 8'h00;
         endcase
      end
   end

   assign cap_data = caps[0];
   assign ser_data = caps[1];
endmodule

// File: rtl/pct_checker.sv
module pct_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        frm_act,
   input logic        pc_vld,
   input logic [2:0]  slot,
   input logic [7:0]  rd_byte,
   input logic [23:0] cap_data,
   input logic [23:0] ser_data
);
   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_vld |=> $stable(cap_data)); // R4
   AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_vld |=> $stable(ser_data)); // R5
   AST_ZERO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      slot == 3'd2 |-> rd_byte == 8'h00); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_act |=> rd_byte == 8'h00); // R8
   AST_SLOT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_act |=> slot == 3'd0); // R8
endmodule

bind pc_trap_capture pct_checker u_chk (
   .clk(clk), .rst_n(rst_n), .frm_act(frm_act), .pc_vld(pc_vld),
   .slot(byte_cnt), .rd_byte(rd_byte), .cap_data(cap_data),
   .ser_data(ser_data)
);

// File: tb/pc_trap_capture_bench.sv
module pc_trap_capture_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_act = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_in = 8'h00;
   logic [7:0]  rd_byte;
   logic        pc_vld = 1'b0;
   logic [8:0]  pc_val = 9'd0;
   logic [95:0] reg_src = '0;
   logic [23:0] cap_data;
   logic [23:0] ser_data;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pc_trap_capture u_pc_trap_capture (
      .clk(clk), .rst_n(rst_n), .frm_act(frm_act), .byte_vld(byte_vld),
      .byte_in(byte_in), .rd_byte(rd_byte), .pc_vld(pc_vld),
      .pc_val(pc_val), .reg_src(reg_src), .cap_data(cap_data),
      .ser_data(ser_data)
   );

   function automatic logic [23:0] srcval(int k, int it);
      return 24'((k + 1) * 24'h210000) ^ 24'(it * 24'h01357) ^ 24'(k * 24'h00F0F);
   endfunction

   task automatic load_src(int it);
      for (int k = 0; k < 4; k++) reg_src[k*24 +: 24] = srcval(k, it);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(logic [7:0] b);
      @(negedge clk);
      byte_vld = 1'b1;
      byte_in  = b;
      @(negedge clk);
      byte_vld = 1'b0;
   endtask

   task automatic close_frame();
      frm_act = 1'b0;
      @(negedge clk);
   endtask

   task automatic setup(logic [9:0] adr, logic [8:0] pc, logic [1:0] sel);
      @(negedge clk);
      frm_act = 1'b1;
      put({5'b0, 1'b0, adr[9:8]});
      put(adr[7:0]);
      put({5'b10101, pc[8:6]});
      put({pc[5:0], sel});
      close_frame();
   endtask

   task automatic hit(logic [8:0] pc);
      @(negedge clk);
      pc_vld = 1'b1;
      pc_val = pc;
      @(negedge clk);
      pc_vld = 1'b0;
   endtask

   task automatic read_unit(logic [9:0] adr, output logic [7:0] z, output logic [23:0] v);
      @(negedge clk);
      frm_act = 1'b1;
      put({5'b0, 1'b1, adr[9:8]});
      put(adr[7:0]);
      z = rd_byte;      put(8'h00);
      v[23:16] = rd_byte; put(8'h00);
      v[15:8]  = rd_byte; put(8'h00);
      v[7:0]   = rd_byte; put(8'h00);
      close_frame();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0]  z;
      logic [23:0] v;
      logic [23:0] prev;
      repeat (3) @(negedge clk);
      chk("R1 cap_data reset", 32'(cap_data), 32'h0);
      chk("R1 ser_data reset", 32'(ser_data), 32'h0);
      chk("R1 rd_byte reset", 32'(rd_byte), 32'h0);
      rst_n = 1'b1;
      load_src(1000);
      hit(9'd0);
      chk("R1 default trap 0 sel 0", 32'(cap_data), 32'(srcval(0, 1000)));
      chk("R1 unit1 default trap", 32'(ser_data), 32'(srcval(0, 1000)));

      // R3 R4 full counter sweep on unit 0
      prev = cap_data;
      for (int pc = 0; pc < 512; pc++) begin
         load_src(pc);
         setup(10'h0F0, 9'(pc), 2'(pc % 4));
         hit(9'((pc + 1) % 512));
         chk("R4 near miss holds", 32'(cap_data), 32'(prev));
         hit(9'(pc));
         chk("R3 R4 match captures select", 32'(cap_data), 32'(srcval(pc % 4, pc)));
         prev = cap_data;
         if (pc % 64 == 7) begin
            read_unit(10'h0F0, z, v);
            chk("R6 zero slot", 32'(z), 32'h0);
            chk("R6 read data", 32'(v), 32'(srcval(pc % 4, pc)));
         end
      end

      // R5 independent units
      load_src(2000);
      setup(10'h0F1, 9'd300, 2'd2);
      setup(10'h0F0, 9'd100, 2'd3);
      hit(9'd300);
      chk("R5 unit1 captures", 32'(ser_data), 32'(srcval(2, 2000)));
      chk("R5 unit0 untouched", 32'(cap_data), 32'(prev));
      load_src(2001);
      hit(9'd100);
      chk("R5 unit0 captures", 32'(cap_data), 32'(srcval(3, 2001)));
      chk("R5 unit1 untouched", 32'(ser_data), 32'(srcval(2, 2000)));
      read_unit(10'h0F1, z, v);
      chk("R5 R6 read unit1", 32'(v), 32'(srcval(2, 2000)));
      read_unit(10'h0F2, z, v);
      chk("R6 unknown address reads zero", 32'(v), 32'h0);

      // R2 bad header ignored
      @(negedge clk);
      frm_act = 1'b1;
      put(8'h40); put(8'hF0); put(8'h00); put({6'd5, 2'd1});
      close_frame();
      load_src(2002);
      hit(9'd5);
      chk("R2 bad header no setup", 32'(cap_data), 32'(srcval(3, 2001)));
      hit(9'd100);
      chk("R2 old trap kept", 32'(cap_data), 32'(srcval(3, 2002)));

      // R8 other address and extra bytes and aborted frame
      setup(10'h0F3, 9'd100, 2'd0);
      load_src(2003);
      hit(9'd100);
      chk("R8 foreign address ignored", 32'(cap_data), 32'(srcval(3, 2003)));
      @(negedge clk);
      frm_act = 1'b1;
      put(8'h00); put(8'hF0); put(8'h00); put({6'd9, 2'd0}); put(8'hFF);
      close_frame();
      load_src(2004);
      hit(9'd9);
      chk("R8 extra byte ignored", 32'(cap_data), 32'(srcval(0, 2004)));
      @(negedge clk);
      frm_act = 1'b1;
      put(8'h00); put(8'hF0); put(8'h01);
      close_frame();
      @(negedge clk);
      frm_act = 1'b1;
      put({6'd20, 2'd1});
      close_frame();
      load_src(2005);
      hit(9'd9);
      chk("R8 aborted frame ignored", 32'(cap_data), 32'(srcval(0, 2005)));

      // R9 write commit and match on same edge
      load_src(2006);
      @(negedge clk);
      frm_act = 1'b1;
      put(8'h00); put(8'hF0); put(8'h00);
      @(negedge clk);
      byte_vld = 1'b1; byte_in = {6'd40, 2'd2};
      pc_vld = 1'b1; pc_val = 9'd9;
      @(negedge clk);
      byte_vld = 1'b0; pc_vld = 1'b0;
      close_frame();
      chk("R9 old setting used", 32'(cap_data), 32'(srcval(0, 2006)));
      load_src(2007);
      hit(9'd40);
      chk("R9 new setting later", 32'(cap_data), 32'(srcval(2, 2007)));

      // R7 capture during read address byte
      prev = cap_data;
      load_src(2008);
      @(negedge clk);
      frm_act = 1'b1;
      put(8'h04);
      @(negedge clk);
      byte_vld = 1'b1; byte_in = 8'hF0;
      pc_vld = 1'b1; pc_val = 9'd40;
      @(negedge clk);
      byte_vld = 1'b0; pc_vld = 1'b0;
      z = rd_byte;        put(8'h00);
      v[23:16] = rd_byte; put(8'h00);
      v[15:8]  = rd_byte; put(8'h00);
      v[7:0]   = rd_byte; put(8'h00);
      chk("R6 slot6 zero", 32'(rd_byte), 32'h0);
      close_frame();
      chk("R7 read returns old value", 32'(v), 32'(prev));
      chk("R7 capture took place", 32'(cap_data), 32'(srcval(2, 2008)));
      chk("R6 R8 idle rd_byte zero", 32'(rd_byte), 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule